// File: doc/BRIEF.md
# Memory Error Status Register Bank

This block keeps per-channel error status for a memory controller with several channels. Each channel owns one 64-bit register. The controller raises single-cycle pulses when it detects errors: link faults on the channel, out-of-range addresses, and correctable or uncorrectable errors seen during scrubbing or normal access. The block latches these pulses into sticky flag bits. Software clears a flag by writing a one to that flag's position. The low 16 bits form a plain read/write field that software owns.

Each error class has overflow tracking. If a correctable error arrives while an earlier correctable error is still flagged, only the correctable overflow flag is set, and the earlier record is left as it was. Uncorrectable errors follow the same rule with their own overflow flag. A second out-of-range access sets a separate repeat flag. The flags are not affected by reset, so software can read the cause of a reset caused by an error after the machine comes back. Their content at power-up is therefore arbitrary, and software clears them first.

A simple bus with separate read and write strobes reaches the registers. Each channel's register sits at its own 4 KiB-spaced byte address. Read data comes back, registered, one cycle after the read strobe.

Top module: `mem_err_status_bank`

## Requirements
- R1: Channel k's register answers only at byte address 0x84_0000_0280 + k*0x1000, for k = 0 to 3. A write to any other address changes nothing, and a read from any other address returns zero.
- R2: `bus_rd_valid` is high in the cycle after each cycle in which `bus_rd_en` is high. In that cycle `bus_rdata` holds the selected register as it stood when the read was requested.
- R3: A write loads bits 15:0 of the write data into bits 15:0 of the register. Synchronous reset clears this field to zero.
- R4: Bits 53:16 always read as zero, whatever has been written to them.
- R5: Flag positions: bit 54 link recoverable, 55 link unrecoverable, 56 repeated out-of-range, 57 out-of-range, 58 scrub uncorrectable, 59 scrub correctable, 60 access uncorrectable, 61 access correctable, 62 correctable overflow, 63 uncorrectable overflow. An error pulse sets its own flag when that flag's class has nothing logged.
- R6: In a write, a one in any of bits 63:54 clears that flag. A zero leaves the flag unchanged.
- R7: If an error sets a flag in the same cycle that a write clears it, the flag ends up set.
- R8: The correctable class is logged when any of bits 54, 59 or 61 is set. A correctable error (link recoverable, scrub correctable or access correctable) that arrives while the class is logged sets only bit 62.
- R9: The uncorrectable class is logged when any of bits 55, 58 or 60 is set. An uncorrectable error (link unrecoverable, scrub uncorrectable or access uncorrectable) that arrives while the class is logged sets only bit 63.
- R10: An out-of-range error sets bit 57 if bit 57 is clear. If bit 57 is already set, it sets bit 56 instead.
- R11: Reset does not change flag bits 63:54.
- R12: Error pulses on one channel change only that channel's register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 40 | Byte address |
| bus_wdata | input | 64 | Write data |
| ev_link_recov | input | 4 | Per-channel link recoverable error pulse |
| ev_link_fatal | input | 4 | Per-channel link unrecoverable error pulse |
| ev_oob | input | 4 | Per-channel out-of-range address error pulse |
| ev_scrub_ue | input | 4 | Per-channel scrub uncorrectable error pulse |
| ev_scrub_ce | input | 4 | Per-channel scrub correctable error pulse |
| ev_acc_ue | input | 4 | Per-channel access uncorrectable error pulse |
| ev_acc_ce | input | 4 | Per-channel access correctable error pulse |
| bus_rdata | output | 64 | Registered read data |
| bus_rd_valid | output | 1 | Read data valid, one cycle after the read strobe |

## Verification
The bench first feeds each channel a first error of each class into an empty class, then a second error of the same class. It reads back whether the error flag was set or whether only the overflow flag moved. For correctable errors it also sends a different source of the same class, which shows that the logged test covers the whole class and not just the flag that is set. Out-of-range errors are sent twice, which separates first capture from the repeat flag. A write that clears a flag in the same cycle as an incoming error shows that the error takes priority. A reset placed between logging and readback separates the flags, which survive reset, from the software field, which is cleared. Writes and reads to addresses next to the register windows show that decoding is exact.

// File: rtl/mem_err_pkg.sv
package mem_err_pkg;

    localparam int REG_W   = 64;
    localparam int SW_W    = 16;
    localparam int FLAG_LO = 54;
    localparam int NFLAG   = REG_W - FLAG_LO;
    localparam int RSV_LO  = SW_W;
    localparam int RSV_HI  = FLAG_LO - 1;

    // flag index, relative to FLAG_LO
    localparam int FL_LINK_RECOV = 0;
    localparam int FL_LINK_FATAL = 1;
    localparam int FL_OOB_MULTI  = 2;
    localparam int FL_OOB        = 3;
    localparam int FL_SCRUB_UE   = 4;
    localparam int FL_SCRUB_CE   = 5;
    localparam int FL_ACC_UE     = 6;
    localparam int FL_ACC_CE     = 7;
    localparam int FL_CE_OVF     = 8;
    localparam int FL_UE_OVF     = 9;

    typedef logic [NFLAG-1:0] flag_vec_t;
    typedef logic [SW_W-1:0]  sw_field_t;

    localparam flag_vec_t CE_MASK = flag_vec_t'((1 << FL_LINK_RECOV) | (1 << FL_SCRUB_CE) | (1 << FL_ACC_CE));
    localparam flag_vec_t UE_MASK = flag_vec_t'((1 << FL_LINK_FATAL) | (1 << FL_SCRUB_UE) | (1 << FL_ACC_UE));

    typedef struct packed {
        logic link_recov;
        logic link_fatal;
        logic oob;
        logic scrub_ue;
        logic scrub_ce;
        logic acc_ue;
        logic acc_ce;
    } err_evt_t;

    function automatic logic ce_logged(flag_vec_t f);
        return |(f & CE_MASK);
    endfunction

    function automatic logic ue_logged(flag_vec_t f);
        return |(f & UE_MASK);
    endfunction

    function automatic logic ce_event(err_evt_t e);
        return e.link_recov | e.scrub_ce | e.acc_ce;
    endfunction

    function automatic logic ue_event(err_evt_t e);
        return e.link_fatal | e.scrub_ue | e.acc_ue;
    endfunction

    function automatic logic [REG_W-1:0] pack_reg(flag_vec_t f, sw_field_t sw);
        return {f, {(RSV_HI - RSV_LO + 1){1'b0}}, sw};
    endfunction

endpackage

// File: rtl/mem_err_addr_dec.sv
module mem_err_addr_dec #(
    parameter int                  ADDR_W    = 40,
    parameter int                  NUM_CH    = 4,
    parameter logic [ADDR_W-1:0]   BASE_ADDR = 40'h84_0000_0280,
    parameter int                  STRIDE    = 4096
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] hit
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_win
        localparam logic [ADDR_W-1:0] CH_ADDR = BASE_ADDR + ADDR_W'(g) * ADDR_W'(STRIDE);
        assign hit[g] = (addr == CH_ADDR);
    end

endmodule

// File: rtl/mem_err_flag_engine.sv
module mem_err_flag_engine
    import mem_err_pkg::*;
(
    input  flag_vec_t cur,
    input  err_evt_t  ev,
    output flag_vec_t set
);

    always_comb begin
        set = '0;
        if (ce_event(ev)) begin
            if (ce_logged(cur)) begin
                set[FL_CE_OVF] = 1'b1;
            end else begin
                set[FL_LINK_RECOV] = ev.link_recov;
                set[FL_SCRUB_CE]   = ev.scrub_ce;
                set[FL_ACC_CE]     = ev.acc_ce;
            end
        end
        if (ue_event(ev)) begin
            if (ue_logged(cur)) begin
                set[FL_UE_OVF] = 1'b1;
            end else begin
                set[FL_LINK_FATAL] = ev.link_fatal;
                set[FL_SCRUB_UE]   = ev.scrub_ue;
                set[FL_ACC_UE]     = ev.acc_ue;
            end
        end
        if (ev.oob) begin
            if (cur[FL_OOB]) set[FL_OOB_MULTI] = 1'b1;
            else             set[FL_OOB]       = 1'b1;
        end
    end

endmodule

// File: rtl/mem_err_chan_reg.sv
module mem_err_chan_reg
    import mem_err_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_sel,
    input  flag_vec_t wr_flags,
    input  sw_field_t wr_sw,
    input  flag_vec_t flag_set,
    output flag_vec_t flags,
    output sw_field_t sw_field
);

    flag_vec_t clr;
    assign clr = wr_sel ? wr_flags : '0;

    // flags deliberately carry no reset
    always_ff @(posedge clk) begin
        flags <= (flags & ~clr) | flag_set;
    end

    always_ff @(posedge clk) begin
        if (rst)         sw_field <= '0;
        else if (wr_sel) sw_field <= wr_sw;
    end

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (flag_set != '0) |=> ((flags & $past(flag_set)) == $past(flag_set)));

    assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && ((wr_flags & ~flag_set) != '0)) |=> ((flags & $past(wr_flags & ~flag_set)) == '0));

    assert_w0_keep_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & ~$past(flags | flag_set)) == '0));

endmodule

// File: rtl/mem_err_rd_port.sv
module mem_err_rd_port
    import mem_err_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rd_en,
    input  logic [NUM_CH-1:0]            hit,
    input  logic [NUM_CH-1:0][REG_W-1:0] reg_img,
    output logic [REG_W-1:0]             rdata,
    output logic                         rd_valid
);

    logic [REG_W-1:0] sel_data;

    always_comb begin
        sel_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit[i]) sel_data = sel_data | reg_img[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rdata    <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rdata <= sel_data;
        end
    end

    assert_rd_lat_R2: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

endmodule

// File: rtl/mem_err_status_bank.sv
module mem_err_status_bank
    import mem_err_pkg::*;
#(
    parameter int                ADDR_W    = 40,
    parameter int                NUM_CH    = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 40'h84_0000_0280,
    parameter int                STRIDE    = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic [NUM_CH-1:0] ev_link_recov,
    input  logic [NUM_CH-1:0] ev_link_fatal,
    input  logic [NUM_CH-1:0] ev_oob,
    input  logic [NUM_CH-1:0] ev_scrub_ue,
    input  logic [NUM_CH-1:0] ev_scrub_ce,
    input  logic [NUM_CH-1:0] ev_acc_ue,
    input  logic [NUM_CH-1:0] ev_acc_ce,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bus_rd_valid
);

    logic [NUM_CH-1:0]            hit;
    logic [NUM_CH-1:0]            wr_hit;
    logic [NUM_CH-1:0][REG_W-1:0] reg_img;

    mem_err_addr_dec #(
        .ADDR_W    (ADDR_W),
        .NUM_CH    (NUM_CH),
        .BASE_ADDR (BASE_ADDR),
        .STRIDE    (STRIDE)
    ) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    assign wr_hit = {NUM_CH{bus_wr_en}} & hit;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        err_evt_t  ev;
        flag_vec_t flags;
        flag_vec_t flag_set;
        sw_field_t sw_field;

        assign ev.link_recov = ev_link_recov[g];
        assign ev.link_fatal = ev_link_fatal[g];
        assign ev.oob        = ev_oob[g];
        assign ev.scrub_ue   = ev_scrub_ue[g];
        assign ev.scrub_ce   = ev_scrub_ce[g];
        assign ev.acc_ue     = ev_acc_ue[g];
        assign ev.acc_ce     = ev_acc_ce[g];

        mem_err_flag_engine u_eng (
            .cur (flags),
            .ev  (ev),
            .set (flag_set)
        );

        mem_err_chan_reg u_reg (
            .clk      (clk),
            .rst      (rst),
            .wr_sel   (wr_hit[g]),
            .wr_flags (bus_wdata[REG_W-1:FLAG_LO]),
            .wr_sw    (bus_wdata[SW_W-1:0]),
            .flag_set (flag_set),
            .flags    (flags),
            .sw_field (sw_field)
        );

        assign reg_img[g] = pack_reg(flags, sw_field);

        assert_ce_ovf_R8: assert property (@(posedge clk) disable iff (rst)
            (ce_event(ev) && ce_logged(flags) && !wr_hit[g])
            |=> (flags[FL_CE_OVF] && $stable(flags & CE_MASK)));

        assert_ue_ovf_R9: assert property (@(posedge clk) disable iff (rst)
            (ue_event(ev) && ue_logged(flags) && !wr_hit[g])
            |=> (flags[FL_UE_OVF] && $stable(flags & UE_MASK)));

        assert_oob_multi_R10: assert property (@(posedge clk) disable iff (rst)
            (ev.oob && flags[FL_OOB] && !wr_hit[g])
            |=> (flags[FL_OOB_MULTI] && flags[FL_OOB]));
    end

    mem_err_rd_port #(
        .NUM_CH (NUM_CH)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (bus_rd_en),
        .hit      (hit),
        .reg_img  (reg_img),
        .rdata    (bus_rdata),
        .rd_valid (bus_rd_valid)
    );

    assert_rsvd_rd_R4: assert property (@(posedge clk) disable iff (rst)
        bus_rd_valid |-> (bus_rdata[RSV_HI:RSV_LO] == '0));

    assert_rsvd_wr_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_rd_en && (|bus_wdata[RSV_HI:RSV_LO])) |=> (bus_rdata[RSV_HI:RSV_LO] == '0));

endmodule

// File: tb/sim_mem_err_status_bank.sv
`timescale 1ns/1ps
module sim_mem_err_status_bank;

    localparam logic [39:0] BASE = 40'h84_0000_0280;
    localparam logic [63:0] FULL = 64'hFFFF_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [39:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [3:0]  ev_link_recov = '0, ev_link_fatal = '0, ev_oob = '0;
    logic [3:0]  ev_scrub_ue = '0, ev_scrub_ce = '0, ev_acc_ue = '0, ev_acc_ce = '0;
    logic [63:0] bus_rdata;
    logic        bus_rd_valid;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [63:0] exp;
        logic [63:0] mask;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #10 clk = ~clk;

    mem_err_status_bank u0 (
        .clk           (clk),
        .rst           (rst),
        .bus_wr_en     (bus_wr_en),
        .bus_rd_en     (bus_rd_en),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .ev_link_recov (ev_link_recov),
        .ev_link_fatal (ev_link_fatal),
        .ev_oob        (ev_oob),
        .ev_scrub_ue   (ev_scrub_ue),
        .ev_scrub_ce   (ev_scrub_ce),
        .ev_acc_ue     (ev_acc_ue),
        .ev_acc_ce     (ev_acc_ce),
        .bus_rdata     (bus_rdata),
        .bus_rd_valid  (bus_rd_valid)
    );

    function automatic logic [39:0] ch_addr(input int ch);
        return BASE + 40'(ch) * 40'd4096;
    endfunction

    // monitor: pops scoreboard entries as read data appears
    always @(negedge clk) begin
        if (!rst && bus_rd_valid) begin
            n_checks++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2: read data valid with no request, act=%h exp=none", bus_rdata);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                if ((bus_rdata & it.mask) !== (it.exp & it.mask)) begin
                    n_fail++;
                    $display("FAIL %s: act=%h exp=%h", it.tag, bus_rdata & it.mask, it.exp & it.mask);
                end
            end
        end
    end

    task automatic rd(input logic [39:0] a, input logic [63:0] exp, input logic [63:0] mask, input string tag);
        @(negedge clk);
        sb_q.push_back('{exp: exp, mask: mask, tag: tag});
        bus_rd_en = 1'b1;
        bus_addr  = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    task automatic wr(input logic [39:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    // kind: 0 link_recov 1 link_fatal 2 oob 3 scrub_ue 4 scrub_ce 5 acc_ue 6 acc_ce
    task automatic set_ev(input int ch, input int kind, input logic v);
        case (kind)
            0: ev_link_recov[ch] = v;
            1: ev_link_fatal[ch] = v;
            2: ev_oob[ch]        = v;
            3: ev_scrub_ue[ch]   = v;
            4: ev_scrub_ce[ch]   = v;
            5: ev_acc_ue[ch]     = v;
            default: ev_acc_ce[ch] = v;
        endcase
    endtask

    task automatic pulse(input int ch, input int kind);
        @(negedge clk);
        set_ev(ch, kind, 1'b1);
        @(negedge clk);
        set_ev(ch, kind, 1'b0);
    endtask

    task automatic finish_run();
        n_checks++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2: reads left unanswered act=%0d exp=0", sb_q.size());
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete act=timeout exp=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R3 reset state of software field, R4 reserved zero (flags undefined)
        for (int c = 0; c < 4; c++)
            rd(ch_addr(c), 64'h0, 64'h003F_FFFF_FFFF_FFFF, "R3 sw field after reset");

        // clear all flags (R6), then all zero
        for (int c = 0; c < 4; c++) wr(ch_addr(c), 64'hFFC0_0000_0000_0000);
        for (int c = 0; c < 4; c++) rd(ch_addr(c), 64'h0, FULL, "R6 flags cleared by ones");

        // R3 software field, R4 reserved writes ignored
        wr(ch_addr(1), 64'h003F_FFFF_FFFF_A5C3);
        rd(ch_addr(1), 64'h0000_0000_0000_A5C3, FULL, "R3 R4 sw load, reserved zero");

        // R5 first correctable access error
        pulse(0, 6);
        rd(ch_addr(0), 64'h2000_0000_0000_0000, FULL, "R5 access correctable bit61");
        // R8 second correctable: only overflow
        pulse(0, 6);
        rd(ch_addr(0), 64'h6000_0000_0000_0000, FULL, "R8 correctable overflow bit62");
        pulse(0, 4);
        rd(ch_addr(0), 64'h6000_0000_0000_0000, FULL, "R8 scrub correctable while logged");

        // R5 / R9 uncorrectable class
        pulse(0, 5);
        rd(ch_addr(0), 64'h7000_0000_0000_0000, FULL, "R5 access uncorrectable bit60");
        pulse(0, 3);
        rd(ch_addr(0), 64'hF000_0000_0000_0000, FULL, "R9 uncorrectable overflow bit63");

        // R10 out-of-range
        pulse(2, 2);
        rd(ch_addr(2), 64'h0200_0000_0000_0000, FULL, "R5 R10 out-of-range bit57");
        pulse(2, 2);
        rd(ch_addr(2), 64'h0300_0000_0000_0000, FULL, "R10 repeat out-of-range bit56");

        // R6 selective clear
        wr(ch_addr(0), 64'h2000_0000_0000_0000);
        rd(ch_addr(0), 64'hD000_0000_0000_0000, FULL, "R6 clear bit61 only");

        // R7 set beats clear in the same cycle
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = ch_addr(2);
        bus_wdata = 64'h0100_0000_0000_0000;
        ev_oob[2] = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        ev_oob[2] = 1'b0;
        rd(ch_addr(2), 64'h0300_0000_0000_0000, FULL, "R7 set wins over clear");
        wr(ch_addr(2), 64'h0100_0000_0000_0000);
        rd(ch_addr(2), 64'h0200_0000_0000_0000, FULL, "R6 clear bit56 alone");

        // R12 channel independence, R5 link flags
        pulse(3, 0);
        rd(ch_addr(3), 64'h0040_0000_0000_0000, FULL, "R5 R12 link recoverable bit54");
        pulse(3, 1);
        rd(ch_addr(3), 64'h00C0_0000_0000_0000, FULL, "R5 link unrecoverable bit55");
        rd(ch_addr(1), 64'h0000_0000_0000_A5C3, FULL, "R12 other channel untouched");

        // R11 flags survive reset, R3 field reset
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd(ch_addr(0), 64'hD000_0000_0000_0000, FULL, "R11 ch0 flags through reset");
        rd(ch_addr(1), 64'h0, FULL, "R3 sw field cleared by reset");
        rd(ch_addr(2), 64'h0200_0000_0000_0000, FULL, "R11 ch2 flags through reset");
        rd(ch_addr(3), 64'h00C0_0000_0000_0000, FULL, "R11 ch3 flags through reset");

        // R1 exact decode
        wr(BASE + 40'h8, FULL);
        wr(ch_addr(4), FULL);
        rd(BASE + 40'h8, 64'h0, FULL, "R1 unmapped read returns zero");
        rd(ch_addr(0), 64'hD000_0000_0000_0000, FULL, "R1 ch0 unaffected by near write");
        rd(ch_addr(3), 64'h00C0_0000_0000_0000, FULL, "R1 ch3 unaffected by write past window");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule